// File: doc/BRIEF.md
# Symmetric Up/Down PWM Compare Timer

This block is an 8-bit timer that counts up from zero to its top value and back down again. A prescaler picks how often the count moves. Two compare channels turn that count into waveforms that are centred on the bottom of the count. Each channel compares its own threshold against the count. A 2-bit output mode per channel selects one of four behaviours:

- non-inverted PWM
- inverted PWM
- disconnected, where the output holds its value
- toggle on match, which only channel A has and which needs a separate enable bit

A one-cycle overflow pulse marks every return of the count to zero.

Threshold inputs are not used straight away. They are copied into the active compare registers only when the count arrives at its top value, so the change happens halfway through a period. Each time the count returns to zero, the PWM level is set again from the active threshold. This keeps the waveform symmetric even when a match was skipped or the threshold has just left its top value.

Top module: `pwmt_phase_pwm`

## Requirements
- R1: The prescale select `clk_sel` maps to a division factor N: 1 gives N=1, 2 gives N=8, 3 gives N=64, 4 gives N=256 and 5 gives N=1024. Codes 0, 6 and 7 stop the count, so no overflow pulse occurs and the outputs do not move.
- R2: Starting from 0, the count rises one step per tick to 255 and then falls one step per tick back to 0. One full period is 510 ticks, so consecutive `ovf` pulses are 510·N clock cycles apart. Each pulse lasts exactly one cycle, in the cycle in which the count holds 0.
- R3: Mode code 2 gives non-inverted PWM. The output goes low when the count reaches the threshold while rising and goes high when the count reaches it while falling. With a steady threshold T, the output is high for 2·T·N cycles per period.
- R4: Mode code 3 gives the inverted waveform of R3. With a steady threshold T, the output is high for (510−2·T)·N cycles per period.
- R5: A threshold of 0 gives a constant low output in mode 2. A threshold of 255 gives a constant high output in mode 2. Mode 3 gives the opposite levels for both.
- R6: A new threshold takes effect only at the tick on which the count reaches 255. In a period during which the threshold moves from T1 to T2 (both between 1 and 254), a mode 2 output is high for (T1+T2)·N cycles.
- R7: When the count arrives at 0, the mode 2/3 level is set to "high when the threshold is nonzero", whether or not a match occurred. For example, after the threshold moves from 255 to 100, the next full period has 200·N high cycles. After it moves from 255 to 0, the next period has no high cycles.
- R8: On channel A, mode code 1 with `tgl_en` set inverts the output on every match. A threshold between 1 and 254 therefore gives two output edges per period.
- R9: Three settings leave the output holding its value: mode code 0 on either channel, mode code 1 on channel B, and mode code 1 on channel A with `tgl_en` clear. The output holds through a whole period with no edges.
- R10: Synchronous reset clears the count to 0 with direction up, drives both outputs and `ovf` low and clears the active thresholds. With N=1, the first `ovf` comes 510 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Prescale select code |
| tgl_en | input | 1 | Enables the toggle mode on channel A |
| mode_a | input | 2 | Output mode, channel A |
| mode_b | input | 2 | Output mode, channel B |
| thr_a | input | 8 | Threshold, channel A (loaded at top of count) |
| thr_b | input | 8 | Threshold, channel B (loaded at top of count) |
| wave_a | output | 1 | Waveform output, channel A |
| wave_b | output | 1 | Waveform output, channel B |
| ovf | output | 1 | One-cycle pulse when the count reaches 0 |

## Verification
The bench builds the block with its default 8-bit count and 10-bit prescale divider. This makes every threshold value usable, including both extremes, while a whole period at N=1 stays at 510 cycles. Because a period is that short, random thresholds in both polarities, the mid-period threshold update and the recovery after leaving 255 can all be measured over several complete periods. The N=8 setting is included so the prescaler's effect on period and duty is seen without reaching the slow divisions.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    CM_OFF    = 2'd0,
    CM_TOGGLE = 2'd1,
    CM_NONINV = 2'd2,
    CM_INV    = 2'd3
  } comp_mode_e;

  typedef struct packed {
    logic       run;
    logic [3:0] shift;
  } div_cfg_t;

  function automatic div_cfg_t decode_sel(input logic [2:0] sel);
    div_cfg_t c;
    c.run   = 1'b1;
    c.shift = 4'd0;
    case (sel)
      3'd1:    c.shift = 4'd0;
      3'd2:    c.shift = 4'd3;
      3'd3:    c.shift = 4'd6;
      3'd4:    c.shift = 4'd8;
      3'd5:    c.shift = 4'd10;
      default: c.run   = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  import pwmt_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  div_cfg_t         cfg;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  always_comb begin
    cfg    = decode_sel(sel_i);
    mask   = DIV_W'((64'd1 << cfg.shift) - 64'd1);
    tick_o = cfg.run && ((div_q & mask) == mask);
  end

endmodule

// File: rtl/pwmt_updown.sv
module pwmt_updown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic             up_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  assign cnt_nx_o = up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
  assign cnt_o    = cnt_q;
  assign up_o     = up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_nx_o;
      if (cnt_nx_o == TOP)      up_q <= 1'b0;
      else if (cnt_nx_o == '0)  up_q <= 1'b1;
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q));

  // R2
  turn_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_q == TOP) |=> (cnt_q == TOP - 1'b1));

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel #(
  parameter int CNT_W      = 8,
  parameter bit HAS_TOGGLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_nx_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [1:0]       mode_i,
  input  logic             tgl_en_i,
  output logic             wave_o
);
  import pwmt_pkg::*;

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] thr_act;
  logic [CNT_W-1:0] thr_eff;
  logic             load, hit, at_bot, inv, lvl_prev, lvl_nx, wave_q, wave_nx;
  comp_mode_e       mode;

  assign mode     = comp_mode_e'(mode_i);
  assign load     = tick_i && (cnt_nx_i == TOP);
  assign thr_eff  = load ? thr_i : thr_act;
  assign hit      = tick_i && (cnt_nx_i == thr_eff);
  assign at_bot   = tick_i && (cnt_nx_i == '0);
  assign inv      = (mode == CM_INV);
  assign lvl_prev = wave_q ^ inv;

  always_comb begin
    if (at_bot)                lvl_nx = (thr_eff != '0);
    else if (hit && cnt_nx_i == TOP) lvl_nx = 1'b1;
    else if (hit)              lvl_nx = !up_i;
    else                       lvl_nx = lvl_prev;
  end

  generate
    if (HAS_TOGGLE) begin : g_tgl
      always_comb begin
        case (mode)
          CM_NONINV: wave_nx = lvl_nx;
          CM_INV:    wave_nx = !lvl_nx;
          CM_TOGGLE: wave_nx = tgl_en_i ? (wave_q ^ hit) : wave_q;
          default:   wave_nx = wave_q;
        endcase
      end
    end else begin : g_notgl
      logic unused_tgl;
      assign unused_tgl = tgl_en_i;
      always_comb begin
        case (mode)
          CM_NONINV: wave_nx = lvl_nx;
          CM_INV:    wave_nx = !lvl_nx;
          default:   wave_nx = wave_q;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_act <= '0;
      wave_q  <= 1'b0;
    end else begin
      if (load) thr_act <= thr_i;
      wave_q <= wave_nx;
    end
  end

  assign wave_o = wave_q;

  // R9
  disc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0) |=> $stable(wave_q));

  // R6
  thr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_act != $past(thr_act)) |-> ($past(tick_i) && $past(cnt_nx_i) == TOP));

endmodule

// File: rtl/pwmt_phase_pwm.sv
module pwmt_phase_pwm #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       clk_sel,
  input  logic             tgl_en,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic [CNT_W-1:0] thr_a,
  input  logic [CNT_W-1:0] thr_b,
  output logic             wave_a,
  output logic             wave_b,
  output logic             ovf
);
  localparam int NCH = 2;

  logic             tick;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             up;
  logic             ovf_q;
  logic [CNT_W-1:0] thr_v  [NCH];
  logic [1:0]       mode_v [NCH];
  logic             wave_v [NCH];

  assign thr_v[0]  = thr_a;
  assign thr_v[1]  = thr_b;
  assign mode_v[0] = mode_a;
  assign mode_v[1] = mode_b;

  pwmt_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .sel_i(clk_sel), .tick_o(tick)
  );

  pwmt_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick),
    .cnt_o(cnt), .cnt_nx_o(cnt_nx), .up_o(up)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      pwmt_channel #(.CNT_W(CNT_W), .HAS_TOGGLE(ch == 0)) u_ch (
        .clk(clk), .rst(rst), .tick_i(tick), .cnt_nx_i(cnt_nx), .up_i(up),
        .thr_i(thr_v[ch]), .mode_i(mode_v[ch]), .tgl_en_i(tgl_en),
        .wave_o(wave_v[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else     ovf_q <= tick && (cnt_nx == '0);
  end

  assign wave_a = wave_v[0];
  assign wave_b = wave_v[1];
  assign ovf    = ovf_q;

  // R2
  ovf_at_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt == '0));

  // R2
  ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q);

endmodule

// File: tb/pwmt_phase_pwm_bench.sv
module pwmt_phase_pwm_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] clk_sel;
  logic       tgl_en;
  logic [1:0] mode_a, mode_b;
  logic [7:0] thr_a, thr_b;
  logic       wave_a, wave_b, ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pwmt_phase_pwm u_pwmt_phase_pwm (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .tgl_en(tgl_en),
    .mode_a(mode_a), .mode_b(mode_b), .thr_a(thr_a), .thr_b(thr_b),
    .wave_a(wave_a), .wave_b(wave_b), .ovf(ovf)
  );

  function automatic int exp_high(input logic [1:0] m, input int t, input int n);
    if (m == 2'd2) return 2 * t * n;
    return (510 - 2 * t) * n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ovf();
    do @(negedge clk); while (!ovf);
  endtask

  // Called at a negedge where ovf is high; measures up to the next pulse.
  task automatic measure(output int cyc, output int ha, output int hb,
                         output int ea, output int eb);
    logic pa, pb;
    cyc = 0; ha = 0; hb = 0; ea = 0; eb = 0;
    pa = wave_a; pb = wave_b;
    ha += int'(wave_a); hb += int'(wave_b);
    forever begin
      @(negedge clk);
      cyc++;
      if (wave_a != pa) ea++;
      if (wave_b != pb) eb++;
      pa = wave_a; pb = wave_b;
      if (ovf) break;
      ha += int'(wave_a); hb += int'(wave_b);
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc, ha, hb, ea, eb, cnt, seed;
    seed = $urandom(32'h5A17C3);
    rst = 1'b1; clk_sel = 3'd1; tgl_en = 1'b0;
    mode_a = 2'd2; mode_b = 2'd3; thr_a = 8'd0; thr_b = 8'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 wave_a reset", int'(wave_a), 0);
    check("R10 wave_b reset", int'(wave_b), 0);
    check("R10 ovf reset", int'(ovf), 0);
    rst = 1'b0;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!ovf);
    check("R10 first ovf delay", cnt, 510);

    // R2 period at N=1, R5 extremes
    thr_a = 8'd255; thr_b = 8'd255;
    wait_ovf(); wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    check("R2 period N=1", cyc, 510);
    check("R5 noninv at 255 high", ha, 510);
    check("R5 inv at 255 low", hb, 0);
    thr_a = 8'd0; thr_b = 8'd0;
    wait_ovf(); wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    check("R5 noninv at 0 low", ha, 0);
    check("R5 inv at 0 high", hb, 510);

    // R1 period at N=8
    clk_sel = 3'd2; thr_a = 8'd37; mode_b = 2'd2; thr_b = 8'd200;
    wait_ovf(); wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    check("R1 period N=8", cyc, 4080);
    check("R3 duty N=8 a", ha, exp_high(2'd2, 37, 8));
    check("R3 duty N=8 b", hb, exp_high(2'd2, 200, 8));

    // R1 stopped codes
    for (int s = 0; s < 2; s++) begin
      clk_sel = (s == 0) ? 3'd0 : 3'd7;
      cnt = 0; ea = 0;
      begin
        logic pa;
        pa = wave_a;
        repeat (1200) begin
          @(negedge clk);
          if (ovf) cnt++;
          if (wave_a != pa) ea++;
          pa = wave_a;
        end
      end
      check("R1 stopped no ovf", cnt, 0);
      check("R1 stopped output still", ea, 0);
    end
    clk_sel = 3'd1;

    // R3 / R4 random thresholds and polarity
    for (int i = 0; i < 10; i++) begin
      int ta, tb;
      logic [1:0] ma, mb;
      ta = int'($urandom_range(0, 255));
      tb = int'($urandom_range(0, 255));
      ma = $urandom_range(0, 1) ? 2'd3 : 2'd2;
      mb = $urandom_range(0, 1) ? 2'd3 : 2'd2;
      thr_a = 8'(ta); thr_b = 8'(tb); mode_a = ma; mode_b = mb;
      wait_ovf(); wait_ovf();
      measure(cyc, ha, hb, ea, eb);
      check((ma == 2'd2) ? "R3 random a" : "R4 random a", ha, exp_high(ma, ta, 1));
      check((mb == 2'd2) ? "R3 random b" : "R4 random b", hb, exp_high(mb, tb, 1));
    end

    // R6 threshold change mid-period
    mode_a = 2'd2; mode_b = 2'd2; thr_a = 8'd50; thr_b = 8'd180;
    wait_ovf(); wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    check("R6 steady before", ha, 100);
    thr_a = 8'd200; thr_b = 8'd3;
    measure(cyc, ha, hb, ea, eb);
    check("R6 split period a", ha, 250);
    check("R6 split period b", hb, 183);
    measure(cyc, ha, hb, ea, eb);
    check("R6 new steady a", ha, 400);

    // R7 leaving the top value
    thr_a = 8'd255; thr_b = 8'd255;
    wait_ovf(); wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    thr_a = 8'd100; thr_b = 8'd0;
    measure(cyc, ha, hb, ea, eb);
    check("R7 transition period a", ha, 510);
    check("R7 transition period b", hb, 510);
    measure(cyc, ha, hb, ea, eb);
    check("R7 after 255->100", ha, 200);
    check("R7 after 255->0", hb, 0);

    // R8 toggle on channel A
    thr_a = 8'd100; thr_b = 8'd100; mode_a = 2'd1; tgl_en = 1'b1;
    wait_ovf(); wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    check("R8 toggle edges", ea, 2);

    // R9 hold modes
    mode_b = 2'd1;
    wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    check("R9 chan B code 1 edges", eb, 0);
    tgl_en = 1'b0;
    wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    check("R9 chan A code 1 no enable edges", ea, 0);
    mode_a = 2'd0; mode_b = 2'd0;
    wait_ovf();
    measure(cyc, ha, hb, ea, eb);
    check("R9 code 0 edges a", ea, 0);
    check("R9 code 0 edges b", eb, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule